// File: doc/BRIEF.md
# Hardware Cursor Sprite Overlay

This block lays a 64x64 two-colour pointer sprite over a stream of display pixels. It sits after the pixel source and before the output stage. Every cycle it is given the raster column and line of the current pixel together with that pixel's colour, and one cycle later it returns either that colour unchanged or one of two sprite colours. The two sprite colours come in on their own inputs, separate from the sprite shape.

The shape is held in internal storage as two one-bit planes: a mask plane that says where the sprite is opaque and an image plane that picks between the two colours. Software loads both planes through one register that sets a word pointer and a second register that stores a word and moves the pointer on by one. A third register carries the sprite origin as two signed coordinates plus an enable bit. That register takes effect only on a frame-start pulse, so a moving pointer never tears within a frame. The origin is the top-left corner of the sprite and there is no hotspot offset. An origin with negative coordinates slides the sprite partly off the top or left edge, and the part still on screen is drawn correctly.

Top module: `sprite_overlay`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pix_out` becomes 0 at that edge. Reset also clears the word pointer to 0 and leaves the sprite disabled, so after reset `pix_out` follows `pix_in`.
- R2: A write with `wr_sel` = 2 (data) stores `wr_data` in the word at the pointer, then adds one to the pointer. The pointer is 8 bits wide and goes from 255 back to 0. A write with `wr_sel` = 1 loads the pointer from `wr_data[7:0]`.
- R3: Words 0 to 127 hold the mask plane and words 128 to 255 hold the image plane. Sprite row r uses plane words 2r (columns 0 to 31) and 2r+1 (columns 32 to 63). Within a word, bit 31 is the leftmost column.
- R4: On a sprite pixel whose mask bit is 0, `pix_out` equals `pix_in`.
- R5: On a sprite pixel whose mask bit is 1, `pix_out` equals `col1` when the image bit is 1 and `col0` when it is 0. The colours are the values present on those inputs in the same cycle as the pixel.
- R6: A write with `wr_sel` = 0 sets the pending position. X is the signed 12-bit field `wr_data[27:16]`, Y is the signed 12-bit field `wr_data[11:0]`, and `wr_data[31]` is the enable.
- R7: While the active enable is 0, `pix_out` equals `pix_in` whatever the sprite planes hold.
- R8: The sprite's top-left pixel sits at the origin (X, Y) with no hotspot offset. When X or Y is negative, only the columns and rows that land at non-negative raster positions are shown, each with its own bitmap bit.
- R9: The pending position and enable are copied to the active set only at a clock edge where `frame_start` is 1. A position write on its own does not change the output.
- R10: `pix_out` is registered. The result for the inputs presented at one clock edge appears on `pix_out` right after that edge.
- R11: A pixel with `pix_x - X` or `pix_y - Y` outside 0..63 gives `pix_out` = `pix_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 position, 1 word pointer, 2 data |
| wr_data | input | 32 | Register write value |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| pix_x | input | 12 | Raster column of the current pixel |
| pix_y | input | 12 | Raster line of the current pixel |
| pix_in | input | 24 | Underlying pixel colour |
| col0 | input | 24 | Sprite colour for image bit 0 |
| col1 | input | 24 | Sprite colour for image bit 1 |
| pix_out | output | 24 | Final pixel colour, one cycle after the inputs |

## Verification
The bench works the edges of the 64x64 window. It checks pixels one step outside each of the four edges and full sweeps of the first, second and last rows. A design with an off-by-one in the range test, or one that swaps the two words of a row, shows the wrong colour there. It moves the origin to negative coordinates and checks that raster (0,0) shows sprite column 10, row 5. A design that treats the coordinates as unsigned, or that clamps them, would draw the sprite far away or start it at column 0. It also writes one word past the end of storage and checks that this word lands in mask word 0. It checks that a position write stays hidden until the frame-start pulse. A design that applies the write at once, or whose pointer does not wrap, fails those checks.

// File: rtl/spr_pkg.sv
// Shared definitions for the cursor sprite overlay.
// Assumes: register selects are two bits wide and drive one register each.
package spr_pkg;
    typedef enum logic [1:0] {
        SEL_POS  = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } spr_sel_e;
endpackage

// File: rtl/spr_regs.sv
// Register file of the sprite overlay: the word pointer that steps on each
// data write, the pending origin/enable, and the active copy taken at frame start.
// Assumes: one write per cycle; frame_start is a single-cycle pulse.
module spr_regs
    import spr_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int COORD_W = 12,
    parameter int AW      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               frame_start,
    output logic               ram_we,
    output logic [AW-1:0]      ram_waddr,
    output logic [WORD_W-1:0]  ram_wdata,
    output logic               act_en,
    output logic [COORD_W-1:0] act_x,
    output logic [COORD_W-1:0] act_y
);
    localparam int X_LSB  = WORD_W / 2;
    localparam int EN_BIT = WORD_W - 1;

    spr_sel_e             sel;
    logic [AW-1:0]        ptr_q;
    logic                 pend_en;
    logic [COORD_W-1:0]   pend_x;
    logic [COORD_W-1:0]   pend_y;
    logic                 unused_wr_bits;

    assign sel            = spr_sel_e'(wr_sel);
    assign ram_we         = wr_en && (sel == SEL_DATA);
    assign ram_waddr      = ptr_q;
    assign ram_wdata      = wr_data;
    assign unused_wr_bits = ^wr_data;

    // Decode register writes into the pointer and the pending position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            pend_en <= 1'b0;
            pend_x  <= '0;
            pend_y  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_POS: begin
                    pend_en <= wr_data[EN_BIT];
                    pend_x  <= wr_data[X_LSB +: COORD_W];
                    pend_y  <= wr_data[COORD_W-1:0];
                end
                SEL_ADDR: ptr_q <= wr_data[AW-1:0];
                SEL_DATA: ptr_q <= ptr_q + AW'(1);
                default:  ;
            endcase
        end
    end

    // Copy the pending position to the active set only at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_en <= 1'b0;
            act_x  <= '0;
            act_y  <= '0;
        end else if (frame_start) begin
            act_en <= pend_en;
            act_x  <= pend_x;
            act_y  <= pend_y;
        end
    end
endmodule

// File: rtl/spr_ram.sv
// Sprite plane storage: one write port, two asynchronous read ports
// (mask and image looked up in the same cycle).
// Assumes: contents are undefined until software loads them.
module spr_ram #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 256,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [WORD_W-1:0] rdata_a,
    output logic [WORD_W-1:0] rdata_b
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Store a loaded word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/spr_locate.sv
// Hit test: turns the raster position and the signed sprite origin into
// an in-window flag, a word index within a plane and a bit position.
// Assumes: raster counters are unsigned; origin is two's complement.
module spr_locate #(
    parameter int SPR_DIM = 64,
    parameter int WORD_W  = 32,
    parameter int COORD_W = 12,
    parameter int PAW     = 7
) (
    input  logic                      en,
    input  logic [COORD_W-1:0]        pix_x,
    input  logic [COORD_W-1:0]        pix_y,
    input  logic [COORD_W-1:0]        org_x,
    input  logic [COORD_W-1:0]        org_y,
    output logic                      hit,
    output logic [PAW-1:0]            word_idx,
    output logic [$clog2(WORD_W)-1:0] bit_pos
);
    localparam int DW  = COORD_W + 2;
    localparam int RW  = $clog2(SPR_DIM);
    localparam int BW  = $clog2(WORD_W);
    localparam int WPR = SPR_DIM / WORD_W;
    localparam logic signed [DW-1:0] LIMIT = DW'(SPR_DIM);
    localparam logic signed [DW-1:0] ZERO  = '0;

    logic signed [DW-1:0] dx;
    logic signed [DW-1:0] dy;
    logic [RW-1:0]        col;
    logic [RW-1:0]        row;

    // Offset of the pixel from the origin, with the origin sign-extended.
    always_comb begin
        dx = $signed({2'b00, pix_x}) - $signed({{2{org_x[COORD_W-1]}}, org_x});
        dy = $signed({2'b00, pix_y}) - $signed({{2{org_y[COORD_W-1]}}, org_y});
    end

    // Window test and plane addressing.
    always_comb begin
        hit      = en && (dx >= ZERO) && (dx < LIMIT) && (dy >= ZERO) && (dy < LIMIT);
        col      = dx[RW-1:0];
        row      = dy[RW-1:0];
        word_idx = PAW'(row) * PAW'(WPR) + PAW'(col >> BW);
        bit_pos  = BW'(WORD_W - 1) - col[BW-1:0];
    end
endmodule

// File: rtl/sprite_overlay.sv
// Cursor sprite overlay top: registers, plane storage, hit test, and the
// registered colour mux that yields the final pixel.
// Assumes: mask plane at word 0, image plane at word PLANE_WORDS.
module sprite_overlay #(
    parameter int SPR_DIM = 64,
    parameter int WORD_W  = 32,
    parameter int COORD_W = 12,
    parameter int COL_W   = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               frame_start,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic [COL_W-1:0]   pix_in,
    input  logic [COL_W-1:0]   col0,
    input  logic [COL_W-1:0]   col1,
    output logic [COL_W-1:0]   pix_out
);
    localparam int WPR         = SPR_DIM / WORD_W;
    localparam int PLANE_WORDS = SPR_DIM * WPR;
    localparam int DEPTH       = 2 * PLANE_WORDS;
    localparam int AW          = $clog2(DEPTH);
    localparam int PAW         = $clog2(PLANE_WORDS);
    localparam int BW          = $clog2(WORD_W);

    logic               ram_we;
    logic [AW-1:0]      ram_waddr;
    logic [WORD_W-1:0]  ram_wdata;
    logic               act_en;
    logic [COORD_W-1:0] act_x;
    logic [COORD_W-1:0] act_y;
    logic               hit;
    logic [PAW-1:0]     word_idx;
    logic [BW-1:0]      bit_pos;
    logic [WORD_W-1:0]  mask_word;
    logic [WORD_W-1:0]  img_word;
    logic               mask_bit;
    logic               img_bit;

    spr_regs #(.WORD_W(WORD_W), .COORD_W(COORD_W), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .frame_start(frame_start),
        .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
        .act_en(act_en), .act_x(act_x), .act_y(act_y)
    );

    spr_ram #(.WORD_W(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .raddr_a({1'b0, word_idx}), .raddr_b({1'b1, word_idx}),
        .rdata_a(mask_word), .rdata_b(img_word)
    );

    spr_locate #(.SPR_DIM(SPR_DIM), .WORD_W(WORD_W), .COORD_W(COORD_W), .PAW(PAW)) u_loc (
        .en(act_en), .pix_x(pix_x), .pix_y(pix_y), .org_x(act_x), .org_y(act_y),
        .hit(hit), .word_idx(word_idx), .bit_pos(bit_pos)
    );

    assign mask_bit = mask_word[bit_pos];
    assign img_bit  = img_word[bit_pos];

    // Pick sprite colour or underlying pixel and register the result.
    always_ff @(posedge clk) begin
        if (!rst_n)               pix_out <= '0;
        else if (hit && mask_bit) pix_out <= img_bit ? col1 : col0;
        else                      pix_out <= pix_in;
    end
endmodule

// File: rtl/spr_overlay_chk.sv
// Checker for the sprite overlay, bound to the top; relates the register,
// hit-test and storage outputs to the registered pixel.
module spr_overlay_chk #(
    parameter int COORD_W = 12,
    parameter int COL_W   = 24,
    parameter int AW      = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [1:0]           wr_sel,
    input logic                 frame_start,
    input logic [COL_W-1:0]     pix_in,
    input logic [COL_W-1:0]     col0,
    input logic [COL_W-1:0]     col1,
    input logic [COL_W-1:0]     pix_out,
    input logic [2*COORD_W:0]   act_pos,
    input logic [AW-1:0]        ptr,
    input logic                 hit,
    input logic                 mask_bit,
    input logic                 img_bit
);
    logic was_rst = 1'b0;

    // Remember whether reset was applied at the previous edge.
    always_ff @(posedge clk) was_rst <= !rst_n;

    // R1: an edge under reset leaves the output cleared.
    always @(posedge clk) begin
        if (was_rst) p_reset_clear_r1: assert (pix_out == '0) else $error("pix_out not cleared");
    end

    p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2) |=> ptr == $past(ptr) + AW'(1));

    p_transparent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !mask_bit) |=> pix_out == $past(pix_in));

    p_colour_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mask_bit) |=> pix_out == ($past(img_bit) ? $past(col1) : $past(col0)));

    p_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !act_pos[2*COORD_W] |=> pix_out == $past(pix_in));

    p_hold_pos_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(act_pos));

    p_outside_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> pix_out == $past(pix_in));
endmodule

bind sprite_overlay spr_overlay_chk #(.COORD_W(COORD_W), .COL_W(COL_W), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .frame_start(frame_start), .pix_in(pix_in), .col0(col0), .col1(col1),
    .pix_out(pix_out), .act_pos({act_en, act_x, act_y}), .ptr(ram_waddr),
    .hit(hit), .mask_bit(mask_bit), .img_bit(img_bit)
);

// File: tb/sprite_overlay_bench.sv
// Scoreboard bench: driver tasks push expected pixels computed from a
// bench-side model of the requirements; a monitor pops and compares them.
module sprite_overlay_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [31:0] wr_data = '0;
    logic        frame_start = 1'b0;
    logic [11:0] pix_x = '0;
    logic [11:0] pix_y = '0;
    logic [23:0] pix_in = '0;
    logic [23:0] col0 = 24'h112233;
    logic [23:0] col1 = 24'hA0B0C0;
    logic [23:0] pix_out;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [23:0] exp_q[$];
    string       tag_q[$];

    // Bench model of the register state, built from the requirements.
    logic [31:0] mem [256];
    logic [7:0]  m_ptr = '0;
    logic        p_en = 1'b0, a_en = 1'b0;
    logic [11:0] p_x = '0, p_y = '0, a_x = '0, a_y = '0;

    always #5 clk = ~clk;

    sprite_overlay u_sprite_overlay (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .frame_start(frame_start), .pix_x(pix_x), .pix_y(pix_y), .pix_in(pix_in),
        .col0(col0), .col1(col1), .pix_out(pix_out)
    );

    function automatic logic [23:0] model_pix(int x, int y, logic [23:0] pin);
        int dx, dy, idx, b;
        if (!rst_n) return 24'h0;
        if (!a_en) return pin;
        dx = x - int'($signed(a_x));
        dy = y - int'($signed(a_y));
        if (dx < 0 || dx > 63 || dy < 0 || dy > 63) return pin;
        idx = dy * 2 + dx / 32;
        b   = 31 - (dx % 32);
        if (!mem[idx][b]) return pin;
        return mem[128 + idx][b] ? col1 : col0;
    endfunction

    function automatic logic [31:0] pattern(int k);
        return (32'(k) * 32'h9E3779B1) ^ 32'h0F0F3333;
    endfunction

    task automatic pix(int x, int y, string tag);
        @(negedge clk);
        pix_x  = 12'(x);
        pix_y  = 12'(y);
        pix_in = {12'(x) ^ 12'h5A5, 12'(y)};
        exp_q.push_back(model_pix(x, y, pix_in));
        tag_q.push_back(tag);
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        case (sel)
            2'd0: begin p_en = d[31]; p_x = d[27:16]; p_y = d[11:0]; end
            2'd1: m_ptr = d[7:0];
            2'd2: begin mem[m_ptr] = d; m_ptr = m_ptr + 8'd1; end
            default: ;
        endcase
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic frame();
        @(negedge clk);
        frame_start = 1'b1;
        a_en = p_en; a_x = p_x; a_y = p_y;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    // Monitor: compare each result just after the edge that registers it.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [23:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (pix_out !== e) begin
                fails++;
                $display("FAIL %s: pix_out=%h expected=%h", t, pix_out, e);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: done=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset clears the output.
        for (int i = 0; i < 3; i++) pix(7 + i, 9, "R1");
        @(negedge clk) rst_n = 1'b1;
        // R1, R10: after reset, disabled sprite passes pixels through one cycle later.
        pix(0, 0, "R1");
        pix(33, 44, "R10");
        pix(100, 50, "R10");

        // Load both planes; the pointer then wraps to 0 (R2, R3).
        wr(2'd1, 32'h0);
        for (int k = 0; k < 256; k++) wr(2'd2, pattern(k));
        wr(2'd2, 32'hFFFF_FFFF);           // R2: wrapped write lands in mask word 0
        wr(2'd1, 32'h80);
        wr(2'd2, 32'h0000_FFFF);           // image word 0

        // R6, R9: origin (100,50) enabled, not yet applied.
        wr(2'd0, {1'b1, 3'b0, 12'd100, 4'b0, 12'd50});
        pix(100, 50, "R9");
        pix(120, 50, "R9");
        frame();
        pix(100, 50, "R2");                // mask all ones, image bit 0 -> col0
        pix(120, 50, "R5");                // image bit 1 -> col1
        pix(99, 50, "R11");
        pix(164, 50, "R11");
        pix(100, 49, "R11");
        pix(100, 114, "R11");
        pix(163, 113, "R6");
        for (int r = 0; r < 64; r += 1) begin
            if (r == 0 || r == 1 || r == 63)
                for (int c = 0; c < 64; c++) pix(100 + c, 50 + r, "R3/R4");
        end
        col1 = 24'h0F0F0F;
        pix(125, 50, "R5");

        // R8: origin (-10,-5) clips the top-left corner.
        wr(2'd0, {1'b1, 3'b0, 12'hFF6, 4'b0, 12'hFFB});
        frame();
        pix(0, 0, "R8");
        for (int c = 0; c < 56; c++) pix(c, 0, "R8");
        for (int c = 0; c < 56; c++) pix(c, 58, "R8");
        pix(54, 0, "R8");
        pix(0, 59, "R8");

        // R7: disable keeps the pass-through even over loaded planes.
        wr(2'd0, {1'b0, 3'b0, 12'hFF6, 4'b0, 12'hFFB});
        pix(0, 0, "R9");
        frame();
        for (int c = 0; c < 20; c++) pix(c, c, "R7");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule